// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one counter channel of an interval timer. It measures time in ticks of a clock-enable input. A load strobe arms it with a 16-bit count and an operating mode. From then on, the output pin produces one of six waveforms: a terminal-count flag, a one-shot window, a rate pulse, a square wave, or a strobe pulse that is either gate-paused or gate-retriggered. The current count is always available on a readback bus.

The gate input has one of two effects, depending on the mode. It either pauses counting, or its rising edge restarts the elapsed interval. Loading zero selects the longest interval, 65536 ticks. Register decoding, byte sequencing, BCD counting and interrupt delivery belong to the surrounding logic.

In the requirements below, N is the loaded interval. The elapsed count d is the number of counted ticks since the last load or restart. A tick is counted on a clock edge where `tick` is high and counting is enabled.

Top module: `interval_counter_ch`

## Requirements
- R1: After reset, `out` is 0 and `count` is 0, and both stay there until the first load, whatever `tick` and `gate` do.
- R2: A load value of 0 is taken as N = 65536.
- R3: On `mode_sel`, codes 0 to 5 select modes 0 to 5. Codes 6 and 7 select modes 2 and 3.
- R4: In modes 0 and 4, ticks are counted only while `gate` is high. In modes 1, 2, 3 and 5, ticks are always counted, and a clock edge that sees `gate` high after it was low sets d to 0.
- R5: Mode 0: `out` = (d >= N). Once high, it stays high until the next load.
- R6: Mode 1: `out` = (d < N).
- R7: Mode 2: `out` = (d != 0 and d mod N == 0). `count` = (N - d mod N) mod 65536.
- R8: Mode 3: `out` = (d mod N < ceil(N/2)). `count` = (N - (2·(d mod N)) mod N) mod 65536.
- R9: Modes 4 and 5: `out` = (d == N), so it is a single counted tick wide.
- R10: In modes 0, 1, 4 and 5, `count` = (N - d) mod 65536. It keeps counting down and wraps past terminal count.
- R11: d changes only on a clock edge with `tick` high and counting enabled, or on a load or restart. A load sets d to 0 and wins over a coincident tick or restart. Outputs show the state after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count clock enable |
| gate | input | 1 | Gate: pause or retrigger, by mode |
| load | input | 1 | Load strobe for value and mode |
| load_value | input | 16 | Interval value (0 means 65536) |
| mode_sel | input | 3 | Operating mode code |
| out | output | 1 | Channel output waveform |
| count | output | 16 | Current count readback |

## Verification
Each mode runs an unbroken tick stream, which separates the level, pulse and square waveforms from one another. Idle-tick gaps show that only enabled ticks advance the count. Gate-low stretches in modes 0 and 4 tell pausing apart from free running. Gate rising edges in modes 1, 2 and 5 tell a restart apart from continued counting. Odd and even intervals in mode 3 expose the duty split and the double-step readback. The 65536-tick interval from a zero load shows the wide terminal compare and the wrap. A load coinciding with a tick shows the load priority.

// File: rtl/ictr_pkg.sv
// Shared types for the interval counter channel.
// Assumes mode codes above 5 fold onto the two periodic modes.
package ictr_pkg;

    typedef enum logic [2:0] {
        M_TERM     = 3'd0,
        M_ONESHOT  = 3'd1,
        M_RATE     = 3'd2,
        M_SQUARE   = 3'd3,
        M_SWSTROBE = 3'd4,
        M_HWSTROBE = 3'd5
    } mode_e;

    // Map a raw 3-bit code onto a supported mode.
    function automatic mode_e fold_mode(input logic [2:0] raw);
        return mode_e'((raw > 3'd5) ? (raw - 3'd4) : raw);
    endfunction

    // Modes where gate level pauses counting.
    function automatic logic is_gated(input mode_e m);
        return (m == M_TERM) || (m == M_SWSTROBE);
    endfunction

    // Modes where the elapsed count wraps at the interval.
    function automatic logic is_periodic(input mode_e m);
        return (m == M_RATE) || (m == M_SQUARE);
    endfunction

endpackage

// File: rtl/ictr_gate_ctl.sv
// Gate handling: turns tick, gate level and gate edges into count-enable
// and restart. Assumes gate is synchronous to clk.
module ictr_gate_ctl
    import ictr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  logic  gate,
    input  logic  active,
    input  mode_e mode,
    output logic  count_en,
    output logic  restart
);

    logic gate_q;

    // Previous gate level for edge detection; treated as high after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= 1'b1;
        else        gate_q <= gate;
    end

    // Enable and retrigger decisions.
    always_comb begin
        count_en = tick && active && (is_gated(mode) ? gate : 1'b1);
        restart  = active && !is_gated(mode) && gate && !gate_q;
    end

endmodule

// File: rtl/ictr_count_core.sv
// Counter state: interval, elapsed count and phase flags.
// Assumes load, restart and count_en are mutually prioritised in that order.
module ictr_count_core
    import ictr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_value,
    input  logic [2:0]       mode_sel,
    input  logic             count_en,
    input  logic             restart,
    output logic             active,
    output mode_e            mode_q,
    output logic [CNT_W:0]   span,
    output logic [CNT_W-1:0] elapsed,
    output logic             reached,
    output logic             hit,
    output logic             started
);

    localparam logic [CNT_W:0] SPAN_MAX = {1'b1, {CNT_W{1'b0}}};
    localparam logic [CNT_W:0] ONE      = {{CNT_W{1'b0}}, 1'b1};

    logic [CNT_W:0] nxt;

    // Elapsed count plus one, one bit wider for the interval compare.
    always_comb nxt = {1'b0, elapsed} + ONE;

    // State update: load, then restart, then counted tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            mode_q  <= M_TERM;
            span    <= '0;
            elapsed <= '0;
            reached <= 1'b0;
            hit     <= 1'b0;
            started <= 1'b0;
        end else if (load) begin
            active  <= 1'b1;
            mode_q  <= fold_mode(mode_sel);
            span    <= (load_value == '0) ? SPAN_MAX : {1'b0, load_value};
            elapsed <= '0;
            reached <= 1'b0;
            hit     <= 1'b0;
            started <= 1'b0;
        end else if (restart) begin
            elapsed <= '0;
            reached <= 1'b0;
            hit     <= 1'b0;
            started <= 1'b0;
        end else if (count_en) begin
            started <= 1'b1;
            if (is_periodic(mode_q)) begin
                elapsed <= (nxt == span) ? '0 : nxt[CNT_W-1:0];
            end else begin
                elapsed <= nxt[CNT_W-1:0];
                if (nxt == span && !reached) begin
                    reached <= 1'b1;
                    hit     <= 1'b1;
                end else begin
                    hit     <= 1'b0;
                end
            end
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !restart && !count_en) |=> ($stable(elapsed) && $stable(reached))); // R11
    AST_PERIOD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (active && is_periodic(mode_q)) |-> ({1'b0, elapsed} < span)); // R7
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && count_en && !load && !restart) |=> !hit); // R9
    AST_MODE_FOLDED: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (3'(mode_q) <= 3'd5)); // R3

endmodule

// File: rtl/ictr_out_decode.sv
// Output waveform and readback value from the counter state.
// Assumes elapsed is below span in the periodic modes.
module ictr_out_decode
    import ictr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             active,
    input  mode_e            mode,
    input  logic [CNT_W:0]   span,
    input  logic [CNT_W-1:0] elapsed,
    input  logic             reached,
    input  logic             hit,
    input  logic             started,
    output logic             out,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W:0] dbl;
    logic [CNT_W:0] dbl_mod;
    logic [CNT_W:0] half;
    logic [CNT_W:0] sq_cnt;

    // Square-wave helpers: doubled phase modulo span and the high-phase length.
    always_comb begin
        dbl     = {elapsed, 1'b0};
        dbl_mod = (dbl >= span) ? (dbl - span) : dbl;
        half    = (span >> 1) + {{CNT_W{1'b0}}, span[0]};
        sq_cnt  = span - dbl_mod;
    end

    // Per-mode output level and readback.
    always_comb begin
        out   = 1'b0;
        count = '0;
        if (active) begin
            count = span[CNT_W-1:0] - elapsed;
            unique case (mode)
                M_TERM:     out = reached;
                M_ONESHOT:  out = !reached;
                M_RATE:     out = started && (elapsed == '0);
                M_SQUARE: begin
                    out   = {1'b0, elapsed} < half;
                    count = sq_cnt[CNT_W-1:0];
                end
                default:    out = hit;
            endcase
        end
    end

endmodule

// File: rtl/interval_counter_ch.sv
// One interval counter channel: gate control, counter core, output decode.
// Assumes all inputs are synchronous to clk; tick paces counting.
module interval_counter_ch
    import ictr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             gate,
    input  logic             load,
    input  logic [CNT_W-1:0] load_value,
    input  logic [2:0]       mode_sel,
    output logic             out,
    output logic [CNT_W-1:0] count
);

    logic             active;
    mode_e            mode_q;
    logic [CNT_W:0]   span;
    logic [CNT_W-1:0] elapsed;
    logic             reached;
    logic             hit;
    logic             started;
    logic             count_en;
    logic             restart;

    ictr_gate_ctl u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .gate     (gate),
        .active   (active),
        .mode     (mode_q),
        .count_en (count_en),
        .restart  (restart)
    );

    ictr_count_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .load_value (load_value),
        .mode_sel   (mode_sel),
        .count_en   (count_en),
        .restart    (restart),
        .active     (active),
        .mode_q     (mode_q),
        .span       (span),
        .elapsed    (elapsed),
        .reached    (reached),
        .hit        (hit),
        .started    (started)
    );

    ictr_out_decode #(.CNT_W(CNT_W)) u_dec (
        .active  (active),
        .mode    (mode_q),
        .span    (span),
        .elapsed (elapsed),
        .reached (reached),
        .hit     (hit),
        .started (started),
        .out     (out),
        .count   (count)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (!out && count == '0)); // R1
    AST_TERM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (active && mode_q == M_TERM && out && !load) |=> out); // R5

endmodule

// File: tb/interval_counter_ch_tb.sv
// Directed bench: each task drives one scenario and compares against an
// elapsed-count model built from the requirements.
module interval_counter_ch_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        gate = 1'b1;
    logic        load = 1'b0;
    logic [15:0] load_value = '0;
    logic [2:0]  mode_sel = '0;
    logic        out;
    logic [15:0] count;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // model state
    bit   loaded = 0;
    int   m_mode = 0;
    int   m_n = 1;
    int   m_d = 0;
    logic gprev = 1'b1;

    interval_counter_ch dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate), .load(load),
        .load_value(load_value), .mode_sel(mode_sel), .out(out), .count(count)
    );

    always #4 clk = ~clk;

    function automatic logic exp_out(int m, int n, int d);
        case (m)
            0: return d >= n;
            1: return d < n;
            2: return (d != 0) && (d % n == 0);
            3: return (d % n) < ((n + 1) / 2);
            default: return d == n;
        endcase
    endfunction

    function automatic int exp_cnt(int m, int n, int d);
        case (m)
            2: return (n - (d % n)) & 16'hFFFF;
            3: return (n - ((2 * (d % n)) % n)) & 16'hFFFF;
            default: return (n - d) & 16'hFFFF;
        endcase
    endfunction

    task automatic compare(input string tag);
        logic eo;
        int   ec;
        eo = loaded ? exp_out(m_mode, m_n, m_d) : 1'b0;
        ec = loaded ? exp_cnt(m_mode, m_n, m_d) : 0;
        checks++;
        if (out !== eo || int'(count) != ec) begin
            errors++;
            $display("FAIL %s d=%0d out=%0b exp=%0b count=%h exp=%h",
                     tag, m_d, out, eo, count, ec[15:0]);
        end
    endtask

    // One clock with the given tick level; model follows R4/R11.
    task automatic step(input logic t, input string tag);
        logic rise;
        tick = t;
        @(posedge clk);
        rise = gate && !gprev;
        gprev = gate;
        if (loaded) begin
            if (rise && (m_mode == 1 || m_mode == 2 || m_mode == 3 || m_mode == 5))
                m_d = 0;
            else if (t && ((m_mode == 0 || m_mode == 4) ? gate : 1'b1))
                m_d++;
        end
        @(negedge clk);
        tick = 1'b0;
        compare(tag);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b1, tag);
    endtask

    // Load strobe, optionally with a coincident tick (R11 priority).
    task automatic do_load(input int md, input int v, input logic t, input string tag);
        load = 1'b1;
        load_value = v[15:0];
        mode_sel = md[2:0];
        tick = t;
        @(posedge clk);
        gprev = gate;
        loaded = 1;
        m_d = 0;
        m_n = (v == 0) ? 65536 : v;
        m_mode = (md > 5) ? md - 4 : md;
        @(negedge clk);
        load = 1'b0;
        tick = 1'b0;
        compare(tag);
    endtask

    task automatic t_reset;
        compare("R1 after reset");
        gate = 1'b0; step(1'b1, "R1 idle tick");
        gate = 1'b1; step(1'b1, "R1 idle gate rise");
        run(3, "R1 idle");
    endtask

    task automatic t_term;
        gate = 1'b1;
        do_load(0, 5, 1'b0, "R5 load");
        run(3, "R5 count");
        step(1'b0, "R11 no tick"); step(1'b0, "R11 no tick");
        gate = 1'b0; run(3, "R4 mode0 paused");
        gate = 1'b1; run(6, "R5 R10 terminal and wrap");
    endtask

    task automatic t_oneshot;
        gate = 1'b1;
        do_load(1, 4, 1'b0, "R6 load");
        run(2, "R6 count");
        gate = 1'b0; step(1'b1, "R4 mode1 gate low counts");
        gate = 1'b1; step(1'b1, "R4 mode1 retrigger");
        run(6, "R6 R10 expire");
    endtask

    task automatic t_rate;
        gate = 1'b1;
        do_load(2, 3, 1'b0, "R7 load");
        run(8, "R7 periodic");
        gate = 1'b0; step(1'b1, "R7 gate low");
        gate = 1'b1; step(1'b1, "R4 mode2 restart");
        run(4, "R7 after restart");
    endtask

    task automatic t_square;
        gate = 1'b1;
        do_load(3, 5, 1'b0, "R8 odd load");
        run(12, "R8 odd");
        do_load(3, 6, 1'b0, "R8 even load");
        run(8, "R8 even");
    endtask

    task automatic t_strobe;
        gate = 1'b1;
        do_load(4, 3, 1'b0, "R9 sw load");
        run(3, "R9 sw reach");
        gate = 1'b0; run(2, "R4 mode4 paused at terminal");
        gate = 1'b1; run(3, "R9 R10 sw after");
        do_load(5, 3, 1'b0, "R9 hw load");
        run(4, "R9 hw pulse");
        gate = 1'b0; step(1'b1, "R9 hw gate low");
        gate = 1'b1; step(1'b1, "R4 mode5 retrigger");
        run(4, "R9 hw second pulse");
    endtask

    task automatic t_alias;
        gate = 1'b1;
        do_load(6, 3, 1'b0, "R3 code6 load");
        run(7, "R3 code6 as rate");
        do_load(7, 4, 1'b0, "R3 code7 load");
        run(6, "R3 code7 as square");
    endtask

    task automatic t_zero;
        gate = 1'b1;
        do_load(0, 0, 1'b0, "R2 zero load");
        run(65540, "R2 R10 full interval");
        do_load(2, 0, 1'b0, "R2 zero rate load");
        run(3, "R2 zero rate");
    endtask

    task automatic t_priority;
        gate = 1'b1;
        do_load(2, 4, 1'b0, "R11 first load");
        run(2, "R11 count");
        do_load(0, 3, 1'b1, "R11 load beats tick");
        run(4, "R11 after reload");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_term();
        t_oneshot();
        t_rate();
        t_square();
        t_strobe();
        t_alias();
        t_priority();
        t_zero();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule